// File: doc/BRIEF.md
# Two-Wire Slave Register Access Engine

This block sits on a two-wire serial bus (I2C) as a slave and turns bus transactions into reads and writes of an external register file. It oversamples SCL and SDA with the system clock, spots start and stop conditions, and checks the 7-bit device address. The five upper bits of that address are fixed by parameter and the two lower bits come from pins. After the address byte, the master sends two subaddress bytes. All bytes after them are data, written to the register file or read back from it.

Registers are one byte wide, with one exception: a single wide register of six bytes. In a burst, the subaddress advances by one after each complete word, and the engine uses the correct word length at each subaddress. The map has reserved holes. These are acknowledged but never written, and they read as one byte of 0x00. When the master clock is reported absent, only the two clock-setup registers accept writes. The register file is reached through a one-cycle write strobe and a combinational read port.

Top module: `i2c_regeng`

## Requirements
- R1: The device address is {5'b01110, addr_sel_i}. A first byte whose upper seven bits match it is acknowledged by holding SDA low through the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R2: A first byte whose address does not match gets no acknowledge. No write follows until the next start condition.
- R3: In a write, the two bytes after the address byte form the subaddress, high byte first. Each complete word of a one-byte register produces one wr_en_o pulse, with the data in wr_data_o[7:0] and the upper bits zero.
- R4: After each complete word (written or read), the subaddress advances by exactly one, so a burst reaches consecutive addresses.
- R5: The register at 0x4002 is six bytes wide. wr_en_o fires once, only after the sixth byte. The first byte sent lands in wr_data_o[47:40]. A read of 0x4002 returns rd_data_i[47:40] first and rd_data_i[7:0] last.
- R6: Holes are 0x4001, 0x4003 to 0x4007, 0x402E and 0x4032 to 0x4035. Writes to a hole are acknowledged but produce no wr_en_o. A read of a hole returns one byte 0x00, whatever rd_data_i holds.
- R7: While mclk_ok_i is low, only 0x4000 and 0x4002 are written. Other addresses are acknowledged but produce no wr_en_o.
- R8: A read drives data MSB first and advances the subaddress per word. After the master does not acknowledge a byte, the engine stops driving SDA.
- R9: A stop condition releases SDA, returns the engine to idle and discards any partly received wide word.
- R10: A repeated start keeps the subaddress, so a write of the subaddress followed by a repeated start and a read returns data from that subaddress.
- R11: Out of reset, SDA is released and wr_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Low two bits of the device address |
| mclk_ok_i | input | 1 | Master clock present |
| wr_en_o | output | 1 | One-cycle write strobe to the register file |
| wr_addr_o | output | 16 | Write address |
| wr_data_o | output | 48 | Write data, right-aligned for one-byte registers |
| rd_addr_o | output | 16 | Current subaddress for reads |
| rd_data_i | input | 48 | Combinational read data at rd_addr_o |

## Verification
The bus inputs pass through two synchronizer stages and one edge register. The engine therefore reacts three to four clock cycles after an SCL edge: an acknowledge or a read bit appears that long after SCL falls, and a write strobe comes that long after the eighth rising edge of the last byte. The bench holds each bus level for eight clock cycles per quarter bit. It samples SDA at the middle of the SCL high phase and checks write counts only after a whole byte, including its ninth clock, has been sent. Every result is therefore settled well before it is sampled, and no check depends on an exact edge.

// File: rtl/i2c_regeng_pkg.sv
package i2c_regeng_pkg;
  localparam int SUB_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_SUBH, PH_SUBL, PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_sync[SYNC_STAGES-1];
      sda_p    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_o      = scl_sync[SYNC_STAGES-1];
  assign sda_o      = sda_sync[SYNC_STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // data edges only count while clock stays high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_regeng_decode.sv
module i2c_regeng_decode #(
  parameter logic [15:0] MAP_BASE  = 16'h4000,
  parameter logic [15:0] WIDE_ADDR = 16'h4002
) (
  input  logic [15:0] addr_i,
  input  logic        mclk_ok_i,
  output logic        hole_o,
  output logic        wide_o,
  output logic        wr_ok_o
);
  localparam logic [5:0] H_SINGLE_A = 6'h01;
  localparam logic [5:0] H_RUN_A_LO = 6'h03;
  localparam logic [5:0] H_RUN_A_HI = 6'h07;
  localparam logic [5:0] H_SINGLE_B = 6'h2E;
  localparam logic [5:0] H_RUN_B_LO = 6'h32;
  localparam logic [5:0] H_RUN_B_HI = 6'h35;

  logic       in_map;
  logic [5:0] off;

  assign in_map = addr_i[15:6] == MAP_BASE[15:6];
  assign off    = addr_i[5:0];
  assign hole_o = in_map && (off == H_SINGLE_A || off == H_SINGLE_B ||
                  (off >= H_RUN_A_LO && off <= H_RUN_A_HI) ||
                  (off >= H_RUN_B_LO && off <= H_RUN_B_HI));
  assign wide_o  = addr_i == WIDE_ADDR;
  assign wr_ok_o = mclk_ok_i || addr_i == MAP_BASE || addr_i == WIDE_ADDR;
endmodule

// File: rtl/i2c_regeng.sv
module i2c_regeng
  import i2c_regeng_pkg::*;
#(
  parameter logic [4:0]  DEV_ADDR_HI = 5'b01110,
  parameter int          MAX_BYTES   = 6,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] MAP_BASE    = 16'h4000,
  parameter logic [15:0] WIDE_ADDR   = 16'h4002
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [1:0]             addr_sel_i,
  input  logic                   mclk_ok_i,
  output logic                   wr_en_o,
  output logic [SUB_W-1:0]       wr_addr_o,
  output logic [MAX_BYTES*8-1:0] wr_data_o,
  output logic [SUB_W-1:0]       rd_addr_o,
  input  logic [MAX_BYTES*8-1:0] rd_data_i
);
  localparam int WORD_W = MAX_BYTES * 8;
  localparam int CNT_W  = $clog2(MAX_BYTES);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(MAX_BYTES - 1);

  logic scl_lvl, sda_lvl, start, stop, scl_rise, scl_fall;
  logic hole, wide, wr_ok, last_byte;

  eng_state_e       state;
  rx_phase_e        phase;
  logic [3:0]       bit_cnt;
  logic [7:0]       shreg, txsr, rx_byte;
  logic             rw, ack_pend, nack;
  logic [SUB_W-1:0] subaddr;
  logic [CNT_W-1:0] byte_pos;
  logic [WORD_W-1:0] wbuf, rbuf, rd_word, tx_word;

  i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_lvl), .sda_o(sda_lvl), .start_o(start), .stop_o(stop),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  i2c_regeng_decode #(.MAP_BASE(MAP_BASE), .WIDE_ADDR(WIDE_ADDR)) u_dec (
    .addr_i(subaddr), .mclk_ok_i, .hole_o(hole), .wide_o(wide), .wr_ok_o(wr_ok)
  );

  assign rd_addr_o = subaddr;
  assign rx_byte   = {shreg[6:0], sda_lvl};
  assign last_byte = wide ? (byte_pos == LAST_POS) : (byte_pos == '0);
  assign rd_word   = hole ? '0 : wide ? rd_data_i :
                     {rd_data_i[7:0], {(WORD_W-8){1'b0}}};
  assign tx_word   = (byte_pos == '0) ? rd_word : rbuf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;  phase <= PH_DEV;  bit_cnt <= '0;
      shreg <= '0;  txsr <= '0;  rw <= 1'b0;  ack_pend <= 1'b0;  nack <= 1'b0;
      subaddr <= '0;  byte_pos <= '0;  wbuf <= '0;  rbuf <= '0;
      sda_oe_o <= 1'b0;  wr_en_o <= 1'b0;  wr_addr_o <= '0;  wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start) begin
        state <= ST_RX;  phase <= PH_DEV;  bit_cnt <= '0;
        byte_pos <= '0;  wbuf <= '0;  sda_oe_o <= 1'b0;
      end else if (stop) begin
        state <= ST_IDLE;  sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bit_cnt < 4'd8) begin
              shreg   <= rx_byte;
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == 4'd7) begin
                ack_pend <= 1'b1;
                unique case (phase)
                  PH_DEV: begin
                    ack_pend <= rx_byte[7:1] == {DEV_ADDR_HI, addr_sel_i};
                    rw       <= rx_byte[0];
                  end
                  PH_SUBH: subaddr[15:8] <= rx_byte;
                  PH_SUBL: subaddr[7:0]  <= rx_byte;
                  default: begin
                    if (last_byte) begin
                      wbuf     <= '0;
                      byte_pos <= '0;
                      subaddr  <= subaddr + 16'd1;
                      if (!hole && wr_ok) begin
                        wr_en_o   <= 1'b1;
                        wr_addr_o <= subaddr;
                        wr_data_o <= {wbuf[WORD_W-9:0], rx_byte};
                      end
                    end else begin
                      wbuf     <= {wbuf[WORD_W-9:0], rx_byte};
                      byte_pos <= byte_pos + 1'b1;
                    end
                  end
                endcase
              end
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (ack_pend) begin
                sda_oe_o <= 1'b1;
                state    <= ST_RX_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (phase == PH_DEV && rw) begin
                state    <= ST_TX;
                txsr     <= tx_word[WORD_W-1 -: 8];
                rbuf     <= tx_word << 8;
                sda_oe_o <= ~tx_word[WORD_W-1];
              end else begin
                state    <= ST_RX;
                sda_oe_o <= 1'b0;
                unique case (phase)
                  PH_DEV:  phase <= PH_SUBH;
                  PH_SUBH: phase <= PH_SUBL;
                  default: phase <= PH_DATA;
                endcase
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_o <= 1'b0;
                state    <= ST_TX_ACK;
              end else begin
                txsr     <= {txsr[6:0], 1'b0};
                sda_oe_o <= ~txsr[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              nack <= sda_lvl;
              if (last_byte) begin
                byte_pos <= '0;
                subaddr  <= subaddr + 16'd1;
              end else begin
                byte_pos <= byte_pos + 1'b1;
              end
            end else if (scl_fall) begin
              if (nack) begin
                state <= ST_IDLE;
              end else begin
                state    <= ST_TX;
                bit_cnt  <= '0;
                txsr     <= tx_word[WORD_W-1 -: 8];
                rbuf     <= tx_word << 8;
                sda_oe_o <= ~tx_word[WORD_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  sda_move_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !$past(start) && !$past(stop)) |-> !scl_lvl);
  // R9
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !sda_oe_o);
  // R6
  hole_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(!hole));
  // R7
  mclk_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !$past(mclk_ok_i)) |-> (wr_addr_o == MAP_BASE || wr_addr_o == WIDE_ADDR));
  // R4
  sub_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> subaddr == wr_addr_o + 16'd1);
  // R3
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R8
  master_ack_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_TX_ACK |-> !sda_oe_o);
endmodule

// File: tb/i2c_regeng_test.sv
module i2c_regeng_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b01;
  logic mclk_ok = 1'b1;
  logic sda_oe, sda_line, wr_en;
  logic [15:0] wr_addr, rd_addr;
  logic [47:0] wr_data, rd_data;

  logic [7:0]  mem [64];
  logic [47:0] pll;
  int          wcnt;
  logic [15:0] wl_addr [32];
  logic [47:0] wl_data [32];
  int total = 0, bad = 0;

  assign sda_line = sda_m & ~sda_oe;
  assign rd_data  = (rd_addr == 16'h4002) ? pll : {40'b0, mem[rd_addr[5:0]]};

  i2c_regeng uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .mclk_ok_i(mclk_ok),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= (i == 1 || i == 3) ? 8'hEE : 8'h00;
      pll  <= '0;
      wcnt <= 0;
    end else if (wr_en) begin
      if (wr_addr == 16'h4002) pll <= wr_data;
      else mem[wr_addr[5:0]] <= wr_data[7:0];
      if (wcnt < 32) begin
        wl_addr[wcnt] <= wr_addr;
        wl_data[wcnt] <= wr_data;
      end
      wcnt <= wcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic b_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic b_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic wb(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    end
    sda_m = 1'b1; wq; scl_m = 1'b1; wq;
    ack = (sda_line == 1'b0);
    wq; scl_m = 1'b0; wq;
  endtask

  task automatic rb(input bit nk, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq; scl_m = 1'b1; wq;
      b = {b[6:0], sda_line};
      wq; scl_m = 1'b0;
    end
    wq; sda_m = nk; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq; sda_m = 1'b1;
  endtask

  task automatic w_head(input logic [15:0] sub, input string req);
    bit a;
    b_start;
    wb(8'h72, a); chk(a, {req, " R1 dev ack"}, 48'(a), 48'd1);
    wb(sub[15:8], a); chk(a, {req, " R3 sub hi ack"}, 48'(a), 48'd1);
    wb(sub[7:0], a); chk(a, {req, " R3 sub lo ack"}, 48'(a), 48'd1);
  endtask

  task automatic t_reset;
    chk(sda_oe == 1'b0, "R11 sda released", 48'(sda_oe), 48'd0);
    chk(wr_en == 1'b0, "R11 no write", 48'(wr_en), 48'd0);
  endtask

  task automatic t_single;
    int w0; bit a;
    w0 = wcnt;
    w_head(16'h400A, "single");
    wb(8'h5A, a); chk(a, "R3 data ack", 48'(a), 48'd1);
    b_stop;
    chk(wcnt == w0 + 1, "R3 write count", 48'(wcnt - w0), 48'd1);
    chk(wl_addr[w0] == 16'h400A, "R3 write addr", 48'(wl_addr[w0]), 48'h400A);
    chk(wl_data[w0] == 48'h5A, "R3 write data", wl_data[w0], 48'h5A);
  endtask

  task automatic t_bad_addr;
    int w0; bit a;
    w0 = wcnt;
    b_start;
    wb(8'h70, a); chk(!a, "R2 mismatch nack", 48'(a), 48'd0);
    wb(8'h40, a); wb(8'h0B, a); wb(8'h99, a);
    chk(!a, "R2 ignored data", 48'(a), 48'd0);
    b_stop;
    chk(wcnt == w0, "R2 no write", 48'(wcnt - w0), 48'd0);
    addr_sel = 2'b10;
    b_start; wb(8'h74, a); b_stop;
    chk(a, "R1 pin address ack", 48'(a), 48'd1);
    b_start; wb(8'h72, a); b_stop;
    chk(!a, "R1 old address nack", 48'(a), 48'd0);
    addr_sel = 2'b01;
  endtask

  task automatic t_burst;
    int w0; bit a;
    w0 = wcnt;
    w_head(16'h4010, "burst");
    wb(8'h11, a); wb(8'h22, a); wb(8'h33, a);
    b_stop;
    chk(wcnt == w0 + 3, "R4 burst count", 48'(wcnt - w0), 48'd3);
    for (int i = 0; i < 3; i++) begin
      chk(wl_addr[w0+i] == 16'h4010 + 16'(i), "R4 burst addr", 48'(wl_addr[w0+i]), 48'(16'h4010 + 16'(i)));
      chk(wl_data[w0+i] == 48'(8'h11 * (i + 1)), "R4 burst data", wl_data[w0+i], 48'(8'h11 * (i + 1)));
    end
  endtask

  task automatic t_wide;
    int w0; bit a;
    w0 = wcnt;
    w_head(16'h4002, "wide");
    for (int i = 0; i < 5; i++) wb(8'hA1 + 8'(i), a);
    chk(wcnt == w0, "R5 no commit before last", 48'(wcnt - w0), 48'd0);
    wb(8'hA6, a);
    chk(wcnt == w0 + 1, "R5 commit after sixth", 48'(wcnt - w0), 48'd1);
    wb(8'h77, a); chk(a, "R6 hole ack", 48'(a), 48'd1);
    wb(8'h88, a);
    b_stop;
    chk(wcnt == w0 + 1, "R6 holes after wide unwritten", 48'(wcnt - w0), 48'd1);
    chk(wl_addr[w0] == 16'h4002, "R5 wide addr", 48'(wl_addr[w0]), 48'h4002);
    chk(wl_data[w0] == 48'hA1A2A3A4A5A6, "R5 wide data", wl_data[w0], 48'hA1A2A3A4A5A6);
  endtask

  task automatic t_hole;
    int w0; bit a;
    w0 = wcnt;
    w_head(16'h402E, "hole");
    wb(8'hFF, a); chk(a, "R6 hole data ack", 48'(a), 48'd1);
    wb(8'h44, a);
    b_stop;
    chk(wcnt == w0 + 1, "R6 hole skipped", 48'(wcnt - w0), 48'd1);
    chk(wl_addr[w0] == 16'h402F, "R4 after hole addr", 48'(wl_addr[w0]), 48'h402F);
    chk(wl_data[w0] == 48'h44, "R4 after hole data", wl_data[w0], 48'h44);
  endtask

  task automatic t_mclk;
    int w0; bit a;
    w0 = wcnt;
    mclk_ok = 1'b0;
    w_head(16'h4000, "mclk");
    wb(8'h07, a); b_stop;
    chk(wcnt == w0 + 1, "R7 open reg written", 48'(wcnt - w0), 48'd1);
    w_head(16'h4010, "mclk");
    wb(8'h55, a); chk(a, "R7 blocked ack", 48'(a), 48'd1);
    b_stop;
    chk(wcnt == w0 + 1, "R7 gated reg blocked", 48'(wcnt - w0), 48'd1);
    w_head(16'h4002, "mclk");
    for (int i = 0; i < 6; i++) wb(8'hB1 + 8'(i), a);
    b_stop;
    chk(wcnt == w0 + 2, "R7 wide reg written", 48'(wcnt - w0), 48'd2);
    chk(wl_data[w0+1] == 48'hB1B2B3B4B5B6, "R7 wide data", wl_data[w0+1], 48'hB1B2B3B4B5B6);
    mclk_ok = 1'b1;
  endtask

  task automatic t_read;
    bit a; logic [7:0] d;
    w_head(16'h4010, "read");
    b_start;
    wb(8'h73, a); chk(a, "R10 read addr ack", 48'(a), 48'd1);
    rb(1'b0, d); chk(d == 8'h11, "R10 read first", 48'(d), 48'h11);
    rb(1'b0, d); chk(d == 8'h22, "R8 read second", 48'(d), 48'h22);
    rb(1'b1, d); chk(d == 8'h33, "R8 read third", 48'(d), 48'h33);
    rb(1'b1, d); chk(d == 8'hFF, "R8 released after nack", 48'(d), 48'hFF);
    b_stop;
  endtask

  task automatic t_read_wide;
    bit a; logic [7:0] d;
    w_head(16'h4001, "rwide");
    b_start;
    wb(8'h73, a);
    rb(1'b0, d); chk(d == 8'h00, "R6 hole reads zero", 48'(d), 48'h00);
    for (int i = 0; i < 6; i++) begin
      rb(1'b0, d); chk(d == 8'hB1 + 8'(i), "R5 wide read byte", 48'(d), 48'(8'hB1 + 8'(i)));
    end
    rb(1'b1, d); chk(d == 8'h00, "R6 hole after wide zero", 48'(d), 48'h00);
    b_stop;
  endtask

  task automatic t_partial;
    int w0; bit a;
    w0 = wcnt;
    w_head(16'h4002, "partial");
    wb(8'hC1, a); wb(8'hC2, a); wb(8'hC3, a);
    b_stop;
    chk(wcnt == w0, "R9 partial discarded", 48'(wcnt - w0), 48'd0);
    chk(sda_oe == 1'b0, "R9 released after stop", 48'(sda_oe), 48'd0);
    w_head(16'h4020, "partial");
    wb(8'h66, a); b_stop;
    chk(wcnt == w0 + 1 && wl_addr[w0] == 16'h4020, "R9 fresh word after stop",
        48'(wl_addr[w0]), 48'h4020);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_single;
    t_bad_addr;
    t_burst;
    t_wide;
    t_hole;
    t_mclk;
    t_read;
    t_read_wide;
    t_partial;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule